// File: doc/BRIEF.md
# Byte-Wide Stored-Program Processor Core

This block is a small multicycle processor. It fetches, decodes and executes one 16-bit instruction at a time. It holds sixteen 8-bit general registers, a program counter and an instruction register. All code and data live in one external 256-byte memory, which the core reaches through a single synchronous byte port with one clock of read latency.

Each instruction occupies two consecutive bytes, high byte first. The top nibble selects the operation and the other three nibbles are operands. The operations are:
- load from memory, load immediate, store to memory and register copy;
- two's-complement add and the three bitwise logic operations;
- rotate right by a count taken from the instruction;
- a jump taken when a chosen register equals register 0;
- halt.

After reset the core sits idle. A pulse on `start` loads the program counter from `start_addr` and begins execution. The `halted` output rises when a halt instruction runs. A read port (`dbg_sel`/`dbg_data`) and `pc_out` show the architectural state.

Top module: `sp_core`

## Requirements
- R1: After reset every register reads 0, `halted` is 0, and no memory read or write is issued until `start` is sampled high; `start` then copies `start_addr` into the program counter.
- R2: An instruction is fetched as the byte at the PC (upper 8 bits) followed by the byte at PC+1 (lower 8 bits). The PC rises by 2 for every instruction, so after a halt `pc_out` equals the halt's address plus 2.
- R3: Opcode 0xC stops the core. `halted` goes high and stays high, the PC holds, and no memory access is made until the next `start`.
- R4: 0x1RXY loads register R from address XY and 0x3RXY writes register R to address XY. Running 156C, 166D, 5056, 306E, C000 from 0xA0 leaves the 8-bit sum of bytes 0x6C and 0x6D at 0x6E.
- R5: 0x2RXY loads register R with the constant XY. 0x40RS copies register R into register S.
- R6: 0x5RST writes (S + T) mod 256 into register R.
- R7: 0x7RST, 0x8RST and 0x9RST write S OR T, S AND T and S XOR T into register R.
- R8: 0xAR0X rotates register R right by (X mod 8) bits, using the low nibble as X; 0xA3 rotated by 1 gives 0xD1.
- R9: 0xBRXY loads the PC with XY when register R equals register 0, and otherwise falls through. With R = 0 the jump is always taken.
- R10: Opcodes 0x0, 0x6, 0xD, 0xE and 0xF, and opcode 0x4 with a nonzero second nibble, change no register and no memory byte; only the PC advances by 2.
- R11: A memory read and a memory write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at `start_addr` (idle or halted only) |
| start_addr | input | 8 | First instruction address |
| mem_addr | output | 8 | Memory byte address |
| mem_rd | output | 1 | Read request; data appears on `mem_rdata` next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after `mem_rd` |
| halted | output | 1 | Core has executed a halt |
| pc_out | output | 8 | Current program counter |
| dbg_sel | input | 4 | Register index for debug view |
| dbg_data | output | 8 | Contents of register `dbg_sel` |

## Verification
The fall-through path of the conditional jump is the hardest case to reach, and so is the proof that a skipped instruction had no effect. The bench builds small programs. Each one loads register 0 and a second register with chosen values, then places a marker load directly after the jump. It sweeps equal and unequal pairs and reads the marker register afterwards. The no-operation encodings are checked the same way: the bench surrounds them with known register contents and compares all sixteen registers and the PC after the halt.

// File: rtl/sp_core.sv
module sp_core #(
  parameter int DW = 8,
  parameter int NREG = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [DW-1:0]           start_addr,
  output logic [DW-1:0]           mem_addr,
  output logic                    mem_rd,
  output logic                    mem_wr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  output logic                    halted,
  output logic [DW-1:0]           pc_out,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic [DW-1:0]           dbg_data
);
  localparam int RW = $clog2(NREG);
  localparam int SW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_F1, S_F2, S_F3, S_EX, S_LD, S_HALT} st_t;
  st_t st;

  logic [DW-1:0]   pc;
  logic [2*DW-1:0] ir;
  logic [DW-1:0]   rf [NREG];

  wire [3:0]    op  = ir[15:12];
  wire [RW-1:0] fr  = ir[11:8];
  wire [RW-1:0] fs  = ir[7:4];
  wire [RW-1:0] ft  = ir[3:0];
  wire [DW-1:0] xy  = ir[7:0];
  wire [DW-1:0] vr  = rf[fr];
  wire [DW-1:0] vs  = rf[fs];
  wire [DW-1:0] vt  = rf[ft];
  wire [2*DW-1:0] dup = {vr, vr} >> ir[SW-1:0];

  logic          we;
  logic [RW-1:0] wa;
  logic [DW-1:0] wd;

  always_comb begin
    we = 1'b0; wa = fr; wd = '0;
    if (st == S_LD) begin
      we = 1'b1; wd = mem_rdata;
    end else if (st == S_EX) begin
      unique case (op)
        4'h2: begin we = 1'b1; wd = xy; end
        4'h4: begin we = (fr == '0); wa = ft; wd = vs; end
        4'h5: begin we = 1'b1; wd = vs + vt; end
        4'h7: begin we = 1'b1; wd = vs | vt; end
        4'h8: begin we = 1'b1; wd = vs & vt; end
        4'h9: begin we = 1'b1; wd = vs ^ vt; end
        4'hA: begin we = 1'b1; wd = dup[DW-1:0]; end
        default: ;
      endcase
    end
  end

  assign mem_rd    = (st == S_F1) || (st == S_F2) || (st == S_EX && op == 4'h1);
  assign mem_wr    = (st == S_EX && op == 4'h3);
  assign mem_addr  = (st == S_F1) ? pc : (st == S_F2) ? pc + 1'b1 : xy;
  assign mem_wdata = vr;
  assign halted    = (st == S_HALT);
  assign pc_out    = pc;
  assign dbg_data  = rf[dbg_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[wa] <= wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pc <= start_addr;
      ir <= '0;
    end else begin
      unique case (st)
        S_IDLE, S_HALT: if (start) begin pc <= start_addr; st <= S_F1; end
        S_F1: st <= S_F2;
        S_F2: begin ir[15:8] <= mem_rdata; st <= S_F3; end
        S_F3: begin ir[7:0] <= mem_rdata; pc <= pc + 2'd2; st <= S_EX; end
        S_EX: begin
          st <= S_F1;
          if (op == 4'h1) st <= S_LD;
          if (op == 4'hC) st <= S_HALT;
          if (op == 4'hB && vr == rf[0]) pc <= xy;
        end
        S_LD: st <= S_F1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!mem_rd && !mem_wr));
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_F3) |=> (pc == $past(pc) + 2'd2));
  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !start) |=> (halted && $stable(pc) && !mem_rd && !mem_wr));
  p_load_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && st == S_EX) |=> (st == S_LD));
  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
endmodule

// File: tb/tb_sp_core.sv
`timescale 1ns/1ps
module tb_sp_core;
  logic clk = 0, rst_n = 0, start = 0;
  logic [7:0] start_addr = 0, mem_addr, mem_wdata, mem_rdata, pc_out, dbg_data;
  logic mem_rd, mem_wr, halted;
  logic [3:0] dbg_sel = 0;
  logic [7:0] mem [256];
  int checks = 0, fails = 0, cyc = 0, both_cnt = 0, idle_acc = 0, halt_acc = 0;

  always #2.5 clk = ~clk;

  sp_core dut (.clk, .rst_n, .start, .start_addr, .mem_addr, .mem_rd, .mem_wr,
               .mem_wdata, .mem_rdata, .halted, .pc_out, .dbg_sel, .dbg_data);

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  logic idle_win = 0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && mem_rd && mem_wr) both_cnt++;
    if (rst_n && idle_win && (mem_rd || mem_wr)) idle_acc++;
    if (rst_n && halted && !start && (mem_rd || mem_wr)) halt_acc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] a, input logic [15:0] w);
    mem[a] = w[15:8];
    mem[a + 8'd1] = w[7:0];
  endtask

  function automatic logic [7:0] reg_of(input logic [3:0] i);
    return 8'h00;
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run(input logic [7:0] base);
    int n;
    @(negedge clk); start_addr = base; start = 1;
    @(negedge clk); start = 0;
    n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    if (!halted) begin fails++; $display("FAIL R3: act=running exp=halted"); end
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] v);
    dbg_sel = i; #0.1; v = dbg_data;
  endtask

  logic [7:0] v;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset();
    // R1: reset state and idle without start
    idle_win = 1;
    repeat (20) @(negedge clk);
    idle_win = 0;
    chk(idle_acc[7:0], 8'd0, "R1 idle memory access");
    chk({7'd0, halted}, 8'd0, "R1 halted after reset");
    for (int i = 0; i < 16; i++) begin rd(i[3:0], v); chk(v, 8'h00, "R1 register reset"); end

    // R4 / R2: sum program swept over operand pairs
    for (int a = 0; a < 256; a += 37) begin
      for (int b = 0; b < 256; b += 29) begin
        do_reset();
        put(8'hA0, 16'h156C); put(8'hA2, 16'h166D); put(8'hA4, 16'h5056);
        put(8'hA6, 16'h306E); put(8'hA8, 16'hC000);
        mem[8'h6C] = a[7:0]; mem[8'h6D] = b[7:0]; mem[8'h6E] = 8'h00;
        run(8'hA0);
        chk(mem[8'h6E], a[7:0] + b[7:0], "R4 stored sum");
        rd(4'h0, v); chk(v, a[7:0] + b[7:0], "R6 sum register");
        chk(pc_out, 8'hAA, "R2 pc after halt");
      end
    end
    // corner: 0xFF + 0x01 wraps
    do_reset();
    mem[8'h6C] = 8'hFF; mem[8'h6D] = 8'h01;
    run(8'hA0);
    chk(mem[8'h6E], 8'h00, "R6 wraparound");

    // R3: halted holds, no access, restart works
    repeat (10) @(negedge clk);
    chk({7'd0, halted}, 8'd1, "R3 stays halted");
    chk(pc_out, 8'hAA, "R3 pc holds");
    chk(halt_acc[7:0], 8'd0, "R3 no access while halted");
    put(8'h40, 16'h2E5A); put(8'h42, 16'hC000);
    run(8'h40);
    rd(4'hE, v); chk(v, 8'h5A, "R3 restart after halt");

    // R5: immediate and copy
    for (int k = 0; k < 8; k++) begin
      do_reset();
      put(8'h10, {4'h2, 4'h7, 8'(k * 33 + 5)});
      put(8'h12, {8'h40, 4'h7, 4'(k + 8)});
      put(8'h14, 16'hC000);
      run(8'h10);
      rd(4'h7, v); chk(v, 8'(k * 33 + 5), "R5 immediate load");
      rd(4'(k + 8), v); chk(v, 8'(k * 33 + 5), "R5 register copy");
    end

    // R7: logic ops swept
    for (int a = 0; a < 256; a += 51) begin
      for (int b = 0; b < 256; b += 43) begin
        do_reset();
        put(8'h20, {8'h21, a[7:0]}); put(8'h22, {8'h22, b[7:0]});
        put(8'h24, 16'h7312); put(8'h26, 16'h8412); put(8'h28, 16'h9512);
        put(8'h2A, 16'hC000);
        run(8'h20);
        rd(4'h3, v); chk(v, a[7:0] | b[7:0], "R7 or");
        rd(4'h4, v); chk(v, a[7:0] & b[7:0], "R7 and");
        rd(4'h5, v); chk(v, a[7:0] ^ b[7:0], "R7 xor");
      end
    end

    // R8: rotate right, all nibble counts
    for (int x = 0; x < 16; x++) begin
      logic [7:0] p, e;
      p = (x == 1) ? 8'hA3 : 8'(x * 23 + 9);
      e = 8'(({p, p} >> (x % 8)) & 16'h00FF);
      do_reset();
      put(8'h30, {8'h21, p}); put(8'h32, {8'hA1, 4'h0, 4'(x)}); put(8'h34, 16'hC000);
      run(8'h30);
      rd(4'h1, v); chk(v, e, "R8 rotate right");
      if (x == 1) chk(v, 8'hD1, "R8 A3 by one");
    end

    // R9: conditional jump, equal and unequal
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int sel = 0; sel < 2; sel++) begin
          do_reset();
          put(8'h50, {8'h20, 8'(a)}); put(8'h52, {8'h22, 8'(b)});
          put(8'h54, {sel == 0 ? 8'hB2 : 8'hB0, 8'h58});
          put(8'h56, 16'h2311); put(8'h58, 16'h2422); put(8'h5A, 16'hC000);
          run(8'h50);
          rd(4'h3, v);
          chk(v, (sel == 1 || a == b) ? 8'h00 : 8'h11, "R9 jump decision");
          rd(4'h4, v); chk(v, 8'h22, "R9 target reached");
        end
      end
    end

    // R10: no-operation encodings
    do_reset();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    put(8'h60, 16'h2155);
    put(8'h62, 16'h0123); put(8'h64, 16'h6123); put(8'h66, 16'hD123);
    put(8'h68, 16'hE123); put(8'h6A, 16'hF123); put(8'h6C, 16'h4113);
    put(8'h6E, 16'hC000);
    run(8'h60);
    for (int i = 0; i < 16; i++) begin
      rd(i[3:0], v); chk(v, (i == 1) ? 8'h55 : 8'h00, "R10 no register change");
    end
    chk(pc_out, 8'h70, "R10 pc advance");
    chk(mem[8'h23], 8'h00, "R10 no memory change");

    chk(both_cnt[7:0], 8'd0, "R11 read and write overlap");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule